// File: doc/BRIEF.md
# Two-Point Linear Voltage Converter

This block turns a raw 12-bit converter code into a voltage in millivolts. A conversion begins with a one-cycle start pulse that carries the code, a 5-bit channel number and a scale flag. The code is first mapped onto one of two fixed calibration lines, each defined by two (millivolt, code) points. The mapping uses linear interpolation with a signed division that truncates toward zero, and any negative result is clamped at zero. Channel 5 uses the high-range line and returns its result directly. Channel 1 uses the low-range line and also returns directly. Every other channel takes the low-range result through a second step, a per-channel rational scaling with rounding.

Both divisions run on one shared restoring divider that produces one quotient bit per cycle, so a conversion takes tens of cycles. While a conversion is in flight, further start pulses are dropped. The result appears on the output together with a one-cycle done pulse, and it stays unchanged until the next done.

Top module: `volt_conv`

## Requirements
- R1: After reset `mv_o` is 0 and `done_o` is 0.
- R2: For channel 5 the result is max(0, trunc(600 × (raw − 2832) / 478) + 3600), where the division truncates toward zero. These values come from the high-range line through (4200 mV, 3310) and (3600 mV, 2832).
- R3: For channel 1 the result is trunc(900 × (raw − 341) / 3072) + 100. These values come from the low-range line through (1000 mV, 3413) and (100 mV, 341). The scale flag has no effect on channel 1.
- R4: The result of either line is never negative. A negative interpolation result is replaced by 0 before any further step.
- R5: Every channel other than 1 and 5 gives (v × den + floor(num / 2)) / num, truncated, where v is the low-range line result of R3 for the same code.
- R6: The ratio num/den is chosen as follows. With the scale flag at 1, channels 2, 3 and 4 use 400/1025 and channels 7 and 8 use 100/125. With the flag at 0, those same channels use 1/1. Channel 6 uses 375/9000 and channel 19 uses 1/3, whatever the flag. All remaining channels use 1/1.
- R7: Each accepted start produces exactly one `done_o` pulse, one cycle wide. `mv_o` carries the result in that same cycle.
- R8: A start that arrives while a conversion is in progress is ignored. It does not change the result of the running conversion and does not produce a done pulse of its own.
- R9: `mv_o` changes only in a cycle where `done_o` is high, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to convert; taken only when idle |
| raw_i | input | 12 | Raw converter code, unsigned |
| chan_i | input | 5 | Channel number, selects line and ratio |
| scale_i | input | 1 | Scale flag, selects the alternative ratio on channels 2-4 and 7-8 |
| mv_o | output | 16 | Converted voltage in millivolts |
| done_o | output | 1 | One-cycle pulse marking a new result on `mv_o` |

## Verification
The hardest case to bring about is a start pulse that lands in the middle of a running conversion. It has to arrive while the shared divider is still busy, and it must carry inputs that would give a clearly different answer. The bench launches a slow ratio-scaled conversion on channel 6. Ten cycles later, while the first division is still under way, it pulses start again with channel 5 and a different code. It then checks that the single done pulse carries the channel 6 value and that no second pulse follows. The rounding and negative-offset paths are reached by sweeping codes on both sides of each line's low calibration code, across all channels with both settings of the scale flag.

// File: rtl/volt_conv_pkg.sv
package volt_conv_pkg;

    // Conversion phases of the top-level sequencer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LINE  = 2'd1,
        ST_RATIO = 2'd2
    } phase_e;

    // Ratio word: numerator in the upper half, denominator in the lower half
    typedef struct packed {
        logic [15:0] num;
        logic [15:0] den;
    } ratio_t;

    // High-range calibration line
    localparam int HI_MV_TOP    = 4200;
    localparam int HI_CODE_TOP  = 3310;
    localparam int HI_MV_BASE   = 3600;
    localparam int HI_CODE_BASE = 2832;

    // Low-range calibration line
    localparam int LO_MV_TOP    = 1000;
    localparam int LO_CODE_TOP  = 3413;
    localparam int LO_MV_BASE   = 100;
    localparam int LO_CODE_BASE = 341;

    // Channels returned straight from a line
    localparam int HI_DIRECT_CH = 5;
    localparam int LO_DIRECT_CH = 1;

endpackage

// File: rtl/vc_ratio_sel.sv
module vc_ratio_sel
    import volt_conv_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic [CH_W-1:0] chan_i,
    input  logic            scale_i,
    output ratio_t          ratio_o
);

    always_comb begin
        ratio_o = '{num: 16'd1, den: 16'd1};
        case (32'(chan_i))
            1, 2, 3, 4: if (scale_i) ratio_o = '{num: 16'd400, den: 16'd1025};
            5:          ratio_o = '{num: 16'd7,   den: 16'd29};
            6:          ratio_o = '{num: 16'd375, den: 16'd9000};
            7, 8:       if (scale_i) ratio_o = '{num: 16'd100, den: 16'd125};
            19:         ratio_o = '{num: 16'd1,   den: 16'd3};
            default:    ratio_o = '{num: 16'd1,   den: 16'd1};
        endcase
    end

endmodule

// File: rtl/vc_restoring_div.sv
module vc_restoring_div #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [DVD_W-1:0] dividend_i,
    input  logic [DVS_W-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [DVD_W-1:0] quotient_o
);

    localparam int CNT_W = (DVD_W > 1) ? $clog2(DVD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DVD_W - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DVD_W-1:0] quo;
        logic [DVS_W-1:0] rem;
        logic [DVS_W-1:0] dvs;
    } div_t;

    div_t div_d, div_q;

    logic [DVS_W:0] trial;
    logic [DVS_W:0] diff;
    logic           qbit;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        trial      = '0;
        diff       = '0;
        qbit       = 1'b0;
        if (!div_q.busy) begin
            if (start_i) begin
                div_d.busy = 1'b1;
                div_d.cnt  = '0;
                div_d.quo  = dividend_i;
                div_d.rem  = '0;
                div_d.dvs  = divisor_i;
            end
        end else begin
            // shift one dividend bit into the partial remainder and try a subtract
            trial = {div_q.rem, div_q.quo[DVD_W-1]};
            diff  = trial - {1'b0, div_q.dvs};
            qbit  = (trial >= {1'b0, div_q.dvs});
            div_d.rem = qbit ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
            div_d.quo = {div_q.quo[DVD_W-2:0], qbit};
            if (div_q.cnt == LAST_STEP) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end else begin
                div_d.cnt = div_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    assign busy_o     = div_q.busy;
    assign done_o     = div_q.done;
    assign quotient_o = div_q.quo;

    // R5
    rem_below_divisor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_q.done |-> (div_q.rem < div_q.dvs));

    // R5
    divisor_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !div_q.busy) |-> (divisor_i != '0));

    // R7
    done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_q.done |-> (!div_q.busy && $past(div_q.busy)));

endmodule

// File: rtl/volt_conv.sv
module volt_conv
    import volt_conv_pkg::*;
#(
    parameter int RAW_W = 12,
    parameter int CH_W  = 5,
    parameter int MV_W  = 16,
    parameter int DIV_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [RAW_W-1:0] raw_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             scale_i,
    output logic [MV_W-1:0]  mv_o,
    output logic             done_o
);

    localparam int RAT_W = $bits(ratio_t) / 2;
    localparam int OFF_W = RAW_W + 2;
    localparam int MAG_W = RAW_W + 1;

    typedef struct packed {
        phase_e          phase;
        logic [CH_W-1:0] chan;
        logic            scale;
        logic            neg;
        logic [MV_W-1:0] mv;
        logic            done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             div_start;
    logic [DIV_W-1:0] div_dvd;
    logic [RAT_W-1:0] div_dvs;
    logic             div_busy;
    logic             div_done;
    logic [DIV_W-1:0] div_quo;
    ratio_t           ratio;

    logic signed [OFF_W-1:0] code_off;
    logic [MAG_W-1:0]        code_mag;
    logic signed [DIV_W:0]   line_v;
    logic [DIV_W-1:0]        volt;

    function automatic logic is_hi(input logic [CH_W-1:0] c);
        return c == CH_W'(HI_DIRECT_CH);
    endfunction

    function automatic logic is_direct(input logic [CH_W-1:0] c);
        return (c == CH_W'(HI_DIRECT_CH)) || (c == CH_W'(LO_DIRECT_CH));
    endfunction

    function automatic int base_code(input logic [CH_W-1:0] c);
        return is_hi(c) ? HI_CODE_BASE : LO_CODE_BASE;
    endfunction

    function automatic int base_mv(input logic [CH_W-1:0] c);
        return is_hi(c) ? HI_MV_BASE : LO_MV_BASE;
    endfunction

    function automatic int span_mv(input logic [CH_W-1:0] c);
        return is_hi(c) ? (HI_MV_TOP - HI_MV_BASE) : (LO_MV_TOP - LO_MV_BASE);
    endfunction

    function automatic int span_code(input logic [CH_W-1:0] c);
        return is_hi(c) ? (HI_CODE_TOP - HI_CODE_BASE) : (LO_CODE_TOP - LO_CODE_BASE);
    endfunction

    function automatic logic [MV_W-1:0] sat_mv(input logic [DIV_W-1:0] x);
        if (|x[DIV_W-1:MV_W]) return '1;
        return x[MV_W-1:0];
    endfunction

    vc_ratio_sel #(
        .CH_W (CH_W)
    ) u_ratio (
        .chan_i  (ctl_q.chan),
        .scale_i (ctl_q.scale),
        .ratio_o (ratio)
    );

    vc_restoring_div #(
        .DVD_W (DIV_W),
        .DVS_W (RAT_W)
    ) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (div_start),
        .dividend_i (div_dvd),
        .divisor_i  (div_dvs),
        .busy_o     (div_busy),
        .done_o     (div_done),
        .quotient_o (div_quo)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        div_start  = 1'b0;
        div_dvd    = '0;
        div_dvs    = '0;
        code_off   = '0;
        code_mag   = '0;
        line_v     = '0;
        volt       = '0;
        case (ctl_q.phase)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.chan  = chan_i;
                    ctl_d.scale = scale_i;
                    // offset from the lower calibration code may be negative
                    code_off  = $signed({2'b00, raw_i}) - $signed(OFF_W'(base_code(chan_i)));
                    ctl_d.neg = code_off[OFF_W-1];
                    code_mag  = ctl_d.neg ? MAG_W'(-code_off) : MAG_W'(code_off);
                    div_dvd   = DIV_W'(code_mag) * DIV_W'(span_mv(chan_i));
                    div_dvs   = RAT_W'(span_code(chan_i));
                    div_start = 1'b1;
                    ctl_d.phase = ST_LINE;
                end
            end
            ST_LINE: begin
                if (div_done) begin
                    // magnitude quotient -> signed, truncated toward zero
                    line_v = ctl_q.neg ? -$signed({1'b0, div_quo}) : $signed({1'b0, div_quo});
                    line_v = line_v + $signed((DIV_W+1)'(base_mv(ctl_q.chan)));
                    volt   = line_v[DIV_W] ? '0 : line_v[DIV_W-1:0];
                    if (is_direct(ctl_q.chan)) begin
                        ctl_d.mv    = sat_mv(volt);
                        ctl_d.done  = 1'b1;
                        ctl_d.phase = ST_IDLE;
                    end else begin
                        div_dvd     = volt * DIV_W'(ratio.den) + DIV_W'(ratio.num >> 1);
                        div_dvs     = ratio.num;
                        div_start   = 1'b1;
                        ctl_d.phase = ST_RATIO;
                    end
                end
            end
            ST_RATIO: begin
                if (div_done) begin
                    ctl_d.mv    = sat_mv(div_quo);
                    ctl_d.done  = 1'b1;
                    ctl_d.phase = ST_IDLE;
                end
            end
            default: ctl_d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign mv_o   = ctl_q.mv;
    assign done_o = ctl_q.done;

    // R7
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9
    mv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(mv_o) |-> done_o);

    // R8
    busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.phase != ST_IDLE) |=> ($stable(ctl_q.chan) && $stable(ctl_q.scale)));

    // R8
    div_engaged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.phase != ST_IDLE) |-> (div_busy || div_done));

    // R3
    direct_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.phase == ST_RATIO) |-> !is_direct(ctl_q.chan));

endmodule

// File: tb/volt_conv_tb.sv
module volt_conv_tb;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [11:0] raw_i = '0;
    logic [4:0]  chan_i = '0;
    logic        scale_i = 1'b0;
    logic [15:0] mv_o;
    logic        done_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk_i = ~clk_i;   // 125 MHz

    volt_conv u_dut (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .raw_i   (raw_i),
        .chan_i  (chan_i),
        .scale_i (scale_i),
        .mv_o    (mv_o),
        .done_o  (done_o)
    );

    function automatic int line_mv(input int raw, input bit hi);
        int q, v;
        if (hi) begin
            q = (600 * (raw - 2832)) / 478;   // truncates toward zero
            v = q + 3600;
        end else begin
            q = (900 * (raw - 341)) / 3072;
            v = q + 100;
        end
        return (v < 0) ? 0 : v;
    endfunction

    function automatic int expect_mv(input int raw, input int ch, input bit sc);
        int v, num, den;
        if (ch == 5) return line_mv(raw, 1'b1);
        v = line_mv(raw, 1'b0);
        if (ch == 1) return v;
        num = 1; den = 1;
        if (ch >= 2 && ch <= 4 && sc) begin num = 400; den = 1025; end
        if (ch == 6)                  begin num = 375; den = 9000; end
        if ((ch == 7 || ch == 8) && sc) begin num = 100; den = 125; end
        if (ch == 19)                 begin num = 1;   den = 3;    end
        return (v * den + num / 2) / num;
    endfunction

    function automatic string req_of(input int ch);
        if (ch == 5) return "R2";
        if (ch == 1) return "R3";
        if ((ch >= 2 && ch <= 4) || ch == 6 || ch == 7 || ch == 8 || ch == 19) return "R6";
        return "R5";
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input int raw, input int ch, input bit sc);
        @(negedge clk_i);
        raw_i = 12'(raw); chan_i = 5'(ch); scale_i = sc; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (done_o) begin seen = 1'b1; break; end
            @(negedge clk_i);
        end
    endtask

    task automatic convert(input int raw, input int ch, input bit sc);
        bit seen;
        int exp, held;
        pulse_start(raw, ch, sc);
        wait_done(seen);
        check("R7", "done seen", int'(seen), 1);
        if (!seen) return;
        exp = expect_mv(raw, ch, sc);
        if (int'(mv_o) != exp)
            $display("  (raw=%0d ch=%0d scale=%0d)", raw, ch, sc);
        check(req_of(ch), "mv", int'(mv_o), exp);
        held = int'(mv_o);
        @(negedge clk_i);
        check("R7", "done width", int'(done_o), 0);
        check("R9", "mv held", int'(mv_o), held);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk_i);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int raws[9] = '{0, 1, 340, 341, 342, 1000, 2047, 3413, 4095};
        bit seen;
        int cnt;
        int exp1;

        repeat (3) @(negedge clk_i);
        // R1: reset state
        check("R1", "mv after reset", int'(mv_o), 0);
        check("R1", "done after reset", int'(done_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1", "done idle", int'(done_o), 0);

        // R2 / R4: high-range line, sweep codes incl. far below base code
        for (int r = 0; r < 4096; r += 5) convert(r, 5, r[0]);
        convert(2832, 5, 1'b0);
        convert(3310, 5, 1'b1);
        convert(4095, 5, 1'b0);

        // R3 / R4: low-range line, scale flag toggled to show it is ignored
        for (int r = 0; r < 4096; r += 9) convert(r, 1, r[1]);
        convert(4095, 1, 1'b1);

        // R5 / R6: every channel, both scale settings
        for (int ch = 0; ch < 32; ch++)
            for (int sc = 0; sc < 2; sc++)
                foreach (raws[k]) convert(raws[k], ch, sc[0]);

        // R8: start pulse while busy is dropped
        exp1 = expect_mv(2000, 6, 1'b0);
        pulse_start(2000, 6, 1'b0);
        repeat (10) @(negedge clk_i);
        raw_i = 12'd100; chan_i = 5'd5; scale_i = 1'b1; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        wait_done(seen);
        check("R8", "done seen", int'(seen), 1);
        check("R8", "mv of first request", int'(mv_o), exp1);
        cnt = 0;
        @(negedge clk_i);
        for (int i = 0; i < 120; i++) begin
            if (done_o) cnt++;
            @(negedge clk_i);
        end
        check("R8", "extra done pulses", cnt, 0);
        check("R9", "mv after idle", int'(mv_o), exp1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule